// File: doc/BRIEF.md
# Dual-Accumulator Multiply-Accumulate Engine

This block is the arithmetic core of a signal-processing path. It multiplies two signed 16-bit working operands and adds the product into one of two 40-bit accumulators, one multiply-accumulate per clock. The product is sign-extended before the add, so the eight bits above the 32-bit product act as guard bits. While a multiply-accumulate runs, the same command can fetch the operands for the next one. An X pointer and a Y pointer each address a small local memory. Both memories are read in the same cycle, and the two values are latched into the working operand registers for the following cycle.

A clear command zeroes the selected accumulator and can start the first fetch in the same cycle, so a series can begin without a dead cycle. Accumulators are read only through a store command. The store writes the middle 16 bits of the selected accumulator into a result register and clamps the value when it no longer fits in a signed 32-bit range. The X memory is written through a general write port. The Y memory is filled through the same port but is read only by the operand fetch.

Top module: `mac_pair_engine`

## Requirements
- R1: After reset the operand registers, both pointers, both accumulators and the result register all read zero.
- R2: When a clear or multiply-accumulate command has `fetch` set, then from the next cycle `wx` and `wy` hold the X memory word at `x_ptr` and the Y memory word at `y_ptr`, as those pointers and memories stood before the edge. Without `fetch` the operands keep their values.
- R3: On a fetch, each pointer advances by one when its own increment flag (`x_inc` or `y_inc`) is set, and it wraps from the last address to zero.
- R4: Command code 2 (multiply-accumulate) adds the signed product of the current `wx` and `wy` into the accumulator chosen by `acc_sel` (0 selects `acc0`, 1 selects `acc1`). The other accumulator is unchanged.
- R5: The product is sign-extended to 40 bits before the add. Sums beyond the 32-bit range are kept exactly, and the total wraps modulo 2^40.
- R6: Command code 1 (clear) sets the selected accumulator to zero. A fetch requested with it is carried out in the same cycle.
- R7: Command code 3 (store) loads `wres` with bits 31:16 of the selected accumulator when that accumulator lies in the signed 32-bit range. Neither accumulator changes.
- R8: A store of an accumulator above the signed 32-bit range gives 0x7FFF. A store of one below that range gives 0x8000.
- R9: Command code 0 (idle) and the store command ignore `fetch`, `x_inc` and `y_inc`. The operands and pointers keep their values.
- R10: When `ptr_ld` is high, both pointers take `x_ptr_in` and `y_ptr_in` at the next edge. The load overrides any post-increment in that cycle.
- R11: When `mem_we` is high, `mem_data` is written at `mem_addr` into the Y memory if `mem_y` is 1, or into the X memory if `mem_y` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cmd | input | 2 | 0 idle, 1 clear, 2 multiply-accumulate, 3 store |
| acc_sel | input | 1 | Target accumulator (0 or 1) |
| fetch | input | 1 | Fetch the next operands (clear and multiply-accumulate only) |
| x_inc | input | 1 | Post-increment the X pointer on a fetch |
| y_inc | input | 1 | Post-increment the Y pointer on a fetch |
| ptr_ld | input | 1 | Load both pointers |
| x_ptr_in | input | AW | New X pointer value |
| y_ptr_in | input | AW | New Y pointer value |
| mem_we | input | 1 | Memory write strobe |
| mem_y | input | 1 | Write target: 1 Y memory, 0 X memory |
| mem_addr | input | AW | Write address |
| mem_data | input | DW | Write data |
| wx | output | DW | X working operand |
| wy | output | DW | Y working operand |
| x_ptr | output | AW | X pointer |
| y_ptr | output | AW | Y pointer |
| acc0 | output | 40 | Accumulator 0 |
| acc1 | output | 40 | Accumulator 1 |
| wres | output | DW | Store result register |

## Verification
The hardest states to reach are the clamp boundaries and the guard-bit region. A single product never leaves the 32-bit range, so only long runs of the most extreme operands get there. The stimulus writes 0x8000 and 0x7FFF at fixed memory addresses and fetches them once. It then repeats the multiply-accumulate without fetching: a few terms step just past each signed 32-bit limit, and several hundred carry the sum through the guard bits and into the 40-bit wrap. A behavioural model is compared against every output on every clock, so a slip in fetch timing or in pointer order shows up in the first cycle it occurs.

// File: rtl/mac_pair_engine.sv
module mac_pair_engine #(
  parameter int DW = 16,
  parameter int AW = 4,
  parameter int GW = 8
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [1:0]          cmd,
  input  logic                acc_sel,
  input  logic                fetch,
  input  logic                x_inc,
  input  logic                y_inc,
  input  logic                ptr_ld,
  input  logic [AW-1:0]       x_ptr_in,
  input  logic [AW-1:0]       y_ptr_in,
  input  logic                mem_we,
  input  logic                mem_y,
  input  logic [AW-1:0]       mem_addr,
  input  logic [DW-1:0]       mem_data,
  output logic [DW-1:0]       wx,
  output logic [DW-1:0]       wy,
  output logic [AW-1:0]       x_ptr,
  output logic [AW-1:0]       y_ptr,
  output logic [2*DW+GW-1:0]  acc0,
  output logic [2*DW+GW-1:0]  acc1,
  output logic [DW-1:0]       wres
);
  localparam int PW    = 2 * DW;
  localparam int AccW  = PW + GW;
  localparam int DEPTH = 1 << AW;
  localparam logic [1:0] OP_IDLE = 2'd0, OP_CLR = 2'd1, OP_MAC = 2'd2, OP_STO = 2'd3;

  logic [DW-1:0]   xmem [DEPTH];
  logic [DW-1:0]   ymem [DEPTH];
  logic [AccW-1:0] acc_q [2];

  always_ff @(posedge clk)
    if (mem_we) begin
      if (mem_y) ymem[mem_addr] <= mem_data;
      else       xmem[mem_addr] <= mem_data;
    end

  logic do_fetch;
  assign do_fetch = fetch && (cmd == OP_CLR || cmd == OP_MAC);

  logic signed [PW-1:0] prod;
  logic [AccW-1:0]      prod_ext;
  assign prod     = $signed(wx) * $signed(wy);
  assign prod_ext = {{GW{prod[PW-1]}}, prod};

  logic [AccW-1:0] sel_acc;
  logic [GW:0]     top_bits;
  logic            fits;
  logic [DW-1:0]   store_val;
  assign sel_acc   = acc_q[acc_sel];
  assign top_bits  = sel_acc[AccW-1:PW-1];
  assign fits      = (&top_bits) || !(|top_bits);
  assign store_val = fits ? sel_acc[PW-1:DW]
                   : (sel_acc[AccW-1] ? {1'b1, {(DW-1){1'b0}}} : {1'b0, {(DW-1){1'b1}}});

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      wx <= '0;
      wy <= '0;
      x_ptr <= '0;
      y_ptr <= '0;
    end else begin
      if (do_fetch) begin
        wx <= xmem[x_ptr];
        wy <= ymem[y_ptr];
      end
      if (ptr_ld) begin
        x_ptr <= x_ptr_in;
        y_ptr <= y_ptr_in;
      end else if (do_fetch) begin
        if (x_inc) x_ptr <= x_ptr + 1'b1;
        if (y_inc) y_ptr <= y_ptr + 1'b1;
      end
    end

  generate
    for (genvar i = 0; i < 2; i++) begin : g_acc
      always_ff @(posedge clk or negedge rst_n)
        if (!rst_n)
          acc_q[i] <= '0;
        else if (acc_sel == 1'(i)) begin
          if (cmd == OP_CLR)      acc_q[i] <= '0;
          else if (cmd == OP_MAC) acc_q[i] <= acc_q[i] + prod_ext;
        end
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)              wres <= '0;
    else if (cmd == OP_STO)  wres <= store_val;

  assign acc0 = acc_q[0];
  assign acc1 = acc_q[1];

  logic unused_ok;
  assign unused_ok = ^{OP_IDLE};
endmodule

// File: rtl/mac_pair_engine_chk.sv
module mac_pair_engine_chk #(
  parameter int DW = 16,
  parameter int AW = 4,
  parameter int GW = 8
) (
  input logic               clk,
  input logic               rst_n,
  input logic [1:0]         cmd,
  input logic               acc_sel,
  input logic               fetch,
  input logic               x_inc,
  input logic               ptr_ld,
  input logic [DW-1:0]      wx,
  input logic [DW-1:0]      wy,
  input logic [AW-1:0]      x_ptr,
  input logic [2*DW+GW-1:0] acc0,
  input logic [2*DW+GW-1:0] acc1,
  input logic [DW-1:0]      wres
);
  localparam int PW   = 2 * DW;
  localparam int AccW = PW + GW;

  a_r6_clear_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd == 2'd1 && !acc_sel) |=> (acc0 == '0));

  a_r4_other_acc_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd == 2'd2 && !acc_sel) |=> $stable(acc1));

  a_r7_store_keeps_acc: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd == 2'd3) |=> ($stable(acc0) && $stable(acc1)));

  a_r9_idle_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd == 2'd0 && !ptr_ld) |=> ($stable(wx) && $stable(wy) && $stable(x_ptr)));

  a_r3_post_inc: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd == 2'd2 && fetch && x_inc && !ptr_ld) |=> (x_ptr == AW'($past(x_ptr) + 1'b1)));

  a_r8_clamp_high: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd == 2'd3 && !acc_sel && !acc0[AccW-1] && (acc0[AccW-1:PW-1] != '0))
      |=> (wres == {1'b0, {(DW-1){1'b1}}}));
endmodule

bind mac_pair_engine mac_pair_engine_chk #(.DW(DW), .AW(AW), .GW(GW)) u_chk (
  .clk(clk), .rst_n(rst_n), .cmd(cmd), .acc_sel(acc_sel), .fetch(fetch),
  .x_inc(x_inc), .ptr_ld(ptr_ld), .wx(wx), .wy(wy), .x_ptr(x_ptr),
  .acc0(acc0), .acc1(acc1), .wres(wres)
);

// File: tb/sim_mac_pair_engine.sv
`timescale 1ns/1ps
module sim_mac_pair_engine;
  logic clk = 0, rst_n = 0;
  logic [1:0] cmd = 0;
  logic acc_sel = 0, fetch = 0, x_inc = 0, y_inc = 0, ptr_ld = 0;
  logic [3:0] x_ptr_in = 0, y_ptr_in = 0, mem_addr = 0;
  logic mem_we = 0, mem_y = 0;
  logic [15:0] mem_data = 0;
  logic [15:0] wx, wy, wres;
  logic [3:0] x_ptr, y_ptr;
  logic [39:0] acc0, acc1;

  always #10 clk = ~clk;

  mac_pair_engine u0 (.*);

  int total = 0, bad = 0;
  string tag = "R1";

  logic [15:0] m_x [16];
  logic [15:0] m_y [16];
  logic [39:0] m_acc [2];
  logic [15:0] m_wx, m_wy, m_wres;
  logic [3:0]  m_xp, m_yp;

  function automatic logic [15:0] clampv(logic [39:0] a);
    longint v = longint'($signed(a));
    if (v > 64'sd2147483647) return 16'h7FFF;
    if (v < -64'sd2147483648) return 16'h8000;
    return a[31:16];
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_acc[0] = 0; m_acc[1] = 0; m_wx = 0; m_wy = 0; m_xp = 0; m_yp = 0; m_wres = 0;
    end else begin
      logic do_f;
      logic [15:0] nx, ny;
      longint p;
      do_f = fetch && (cmd == 1 || cmd == 2);
      nx = m_x[m_xp];
      ny = m_y[m_yp];
      p = longint'($signed(m_wx)) * longint'($signed(m_wy));
      if (cmd == 1) m_acc[acc_sel] = 0;
      if (cmd == 2) m_acc[acc_sel] = m_acc[acc_sel] + 40'(p);
      if (cmd == 3) m_wres = clampv(m_acc[acc_sel]);
      if (do_f) begin m_wx = nx; m_wy = ny; end
      if (ptr_ld) begin m_xp = x_ptr_in; m_yp = y_ptr_in; end
      else if (do_f) begin
        if (x_inc) m_xp = m_xp + 1;
        if (y_inc) m_yp = m_yp + 1;
      end
      if (mem_we) begin
        if (mem_y) m_y[mem_addr] = mem_data; else m_x[mem_addr] = mem_data;
      end
    end
  end

  task automatic compare();
    total++;
    if (wx !== m_wx || wy !== m_wy || x_ptr !== m_xp || y_ptr !== m_yp ||
        acc0 !== m_acc[0] || acc1 !== m_acc[1] || wres !== m_wres) begin
      bad++;
      $display("FAIL %s t=%0t got wx=%h wy=%h xp=%0d yp=%0d a0=%h a1=%h r=%h exp wx=%h wy=%h xp=%0d yp=%0d a0=%h a1=%h r=%h",
        tag, $time, wx, wy, x_ptr, y_ptr, acc0, acc1, wres,
        m_wx, m_wy, m_xp, m_yp, m_acc[0], m_acc[1], m_wres);
    end
  endtask

  task automatic step(input logic [1:0] c, input logic s, input logic f,
                      input logic xi, input logic yi);
    cmd = c; acc_sel = s; fetch = f; x_inc = xi; y_inc = yi;
    @(negedge clk);
    compare();
    ptr_ld = 0; mem_we = 0;
  endtask

  task automatic loadptr(input logic [3:0] xp, input logic [3:0] yp);
    ptr_ld = 1; x_ptr_in = xp; y_ptr_in = yp;
    step(0, 0, 1, 1, 1);
  endtask

  task automatic wmem(input logic y, input logic [3:0] a, input logic [15:0] d);
    mem_we = 1; mem_y = y; mem_addr = a; mem_data = d;
    step(0, 0, 0, 0, 0);
  endtask

  initial begin
    #(200000 * 20);
    bad++;
    $display("FAIL watchdog expired");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [7:0] lf;
    repeat (3) @(negedge clk);
    compare();                          // R1 values during reset
    rst_n = 1;
    @(negedge clk); compare();          // R1 after release
    tag = "R11";
    for (int i = 0; i < 14; i++) begin
      wmem(0, 4'(i), 16'(i * 1234 - 9000));
      wmem(1, 4'(i), 16'(7000 - i * 2311));
    end
    wmem(0, 14, 16'h8000); wmem(1, 14, 16'h8000);
    wmem(0, 15, 16'h8000); wmem(1, 15, 16'h7FFF);
    tag = "R10";                        // load beats post-increment on a fetch
    ptr_ld = 1; x_ptr_in = 0; y_ptr_in = 0;
    step(2, 1, 1, 1, 1);
    tag = "R6";
    step(1, 0, 1, 1, 1);
    step(1, 1, 1, 1, 1);
    tag = "R4";
    for (int i = 0; i < 10; i++) step(2, 1'(i % 3 == 0), 1, 1, 1'(i % 2));
    tag = "R7";
    step(3, 0, 0, 0, 0);
    step(3, 1, 0, 0, 0);
    tag = "R9";
    step(0, 0, 1, 1, 1);
    step(3, 1, 1, 1, 1);
    step(0, 1, 1, 0, 1);
    tag = "R2";
    for (int i = 0; i < 3; i++) step(2, 0, 0, 1, 1);
    tag = "R8";
    loadptr(14, 14);
    step(1, 0, 1, 0, 0);
    for (int i = 0; i < 3; i++) step(2, 0, 0, 0, 0);
    step(3, 0, 0, 0, 0);                // 3*2^30 fits
    step(2, 0, 0, 0, 0);
    step(3, 0, 0, 0, 0);                // 2^32 clamps to 7FFF
    loadptr(15, 15);
    step(1, 1, 1, 0, 0);
    step(2, 1, 0, 0, 0); step(2, 1, 0, 0, 0);
    step(3, 1, 0, 0, 0);                // just inside negative limit
    step(2, 1, 0, 0, 0);
    step(3, 1, 0, 0, 0);                // clamps to 8000
    tag = "R3";
    loadptr(15, 15);
    step(2, 0, 1, 1, 1);                // wraps to 0
    step(2, 0, 1, 1, 0);
    step(1, 1, 1, 0, 1);
    tag = "R5";
    loadptr(14, 14);
    step(1, 0, 1, 0, 0);
    for (int i = 0; i < 1100; i++) step(2, 0, 0, 0, 0);
    step(3, 0, 0, 0, 0);
    tag = "R4";
    lf = 8'h5A;
    for (int i = 0; i < 300; i++) begin
      lf = {lf[6:0], lf[7] ^ lf[5] ^ lf[4] ^ lf[3]};
      if (lf[7:6] == 0) ptr_ld = lf[5];
      x_ptr_in = lf[3:0]; y_ptr_in = lf[7:4];
      step(lf[1:0], lf[2], lf[3], lf[4], lf[5]);
    end
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule